// File: doc/BRIEF.md
# NOR Flash Byte Program Sequencer

This block writes a run of bytes into an 8-bit NOR flash device. A request gives a start address and a length. The block fetches each byte from a data source port, indexed by its offset within the request. Before programming a byte, the block reads the byte already held at the target address. If that byte already matches, the block moves on without writing. If it does not match, the block sends the three-write unlock and program command, writes the data byte and then polls the target address until the device stops changing.

The block keeps the latest status reads in a four-slot ring. Completion is found when two reads in a row are equal, or when a read ceiling is reached. Success means the final read equals the wanted byte. On failure, an older status byte is inspected to tell an internal device fault apart from a program that did not take, and the rest of the request is abandoned. A request that runs past the end of the device is refused before any bus cycle. A warning is raised when any byte asks for a bit to go from 0 to 1, which erased-state flash cannot do by programming.

Top module: `nfps_prog`

## Requirements
- R1: When the byte read from the target equals the wanted byte, no write cycle is issued for it and the byte counts as a success.
- R2: `warn` is 1 at completion when any attempted byte of the request had a bit at 1 in the wanted value and at 0 in the old value; such a byte is still programmed.
- R3: Programming one byte issues exactly four writes in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, then the data byte to the target address.
- R4: After the data write, the block makes at least three status reads of the target address. It then stops at the first read that equals the read before it, or at the POLL_MAX-th read, whichever comes first.
- R5: A programmed byte succeeds only if the last status read equals the wanted byte; otherwise the request ends with an error.
- R6: On failure, bit 5 of the status read taken two reads before the last one selects the class: set gives `err_kind` 2 (internal fault), clear gives `err_kind` 3 (program did not take).
- R7: Bytes are handled at ascending addresses from the start address, and a failed byte ends the request with later bytes left untouched.
- R8: A request with start address plus length above DEV_SIZE ends with `err_kind` 1 and no read or write cycle at all; a request ending exactly at DEV_SIZE is accepted.
- R9: A zero-length request completes with `err_kind` 0 and no bus cycle.
- R10: After reset, `busy`, `done`, `err`, `fl_re` and `fl_we` are 0.
- R11: `done` pulses for one cycle per request; `err` is 1 exactly when `err_kind` is not 0 (0 success).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Start a request (taken while idle) |
| req_addr | input | AW | Device start address |
| req_len | input | LW | Number of bytes |
| src_idx | output | LW | Offset of the byte wanted from the source |
| src_byte | input | 8 | Source byte at `src_idx` (same cycle) |
| fl_re | output | 1 | Flash read cycle |
| fl_we | output | 1 | Flash write cycle |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, sampled in a read cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with `done`) |
| err_kind | output | 2 | 0 ok, 1 range, 2 internal fault, 3 not taken |
| warn | output | 1 | A 0-to-1 bit change was requested |

## Verification
The bench builds the block with a 12-bit address, a 64-byte device and a poll ceiling of 16 reads. With these values the read ceiling, the exact end-of-device boundary and every old/new byte pairing in a swept set can all be reached within a few thousand cycles. A behavioural flash model in the bench counts read and write cycles and checks the command order. It can hold a fault bit in its status, or keep toggling forever. Expected classes, warnings, memory contents and cycle counts are all worked out arithmetically from the byte values.

// File: rtl/nfps_pkg.sv
package nfps_pkg;

   typedef enum logic [1:0] {
      NFP_OK       = 2'd0,
      NFP_RANGE    = 2'd1,
      NFP_INTERNAL = 2'd2,
      NFP_NOTAKE   = 2'd3
   } nfp_err_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHK,
      ST_RDOLD,
      ST_U1,
      ST_U2,
      ST_U3,
      ST_WR,
      ST_POLL,
      ST_DONE
   } nfp_st_e;

   localparam logic [7:0] CMD_UNL1 = 8'hAA;
   localparam logic [7:0] CMD_UNL2 = 8'h55;
   localparam logic [7:0] CMD_PROG = 8'hA0;
   localparam int         STAT_FAULT_BIT = 5;
   localparam int         RING_DEPTH = 4;

endpackage

// File: rtl/nfps_cmd.sv
module nfps_cmd #(
   parameter int AW = 20,
   parameter logic [AW-1:0] UNLOCK_A = AW'(12'h555),
   parameter logic [AW-1:0] UNLOCK_B = AW'(12'h2AA)
) (
   input  logic [1:0]    step,
   output logic [AW-1:0] cmd_addr,
   output logic [7:0]    cmd_data
);
   import nfps_pkg::*;

   always_comb begin
      case (step)
         2'd0:    begin cmd_addr = UNLOCK_A; cmd_data = CMD_UNL1; end
         2'd1:    begin cmd_addr = UNLOCK_B; cmd_data = CMD_UNL2; end
         default: begin cmd_addr = UNLOCK_A; cmd_data = CMD_PROG; end
      endcase
   end

endmodule

// File: rtl/nfps_ring.sv
module nfps_ring #(
   parameter int POLL_MAX = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       sample,
   input  logic [7:0] rd,
   input  logic [7:0] target,
   output logic       fin,
   output logic       pass,
   output logic       fault
);
   import nfps_pkg::*;

   localparam int CW = $clog2(POLL_MAX + 1);

   logic [CW-1:0] cnt;
   logic [CW:0]   cnt_n;
   logic [7:0]    slot [RING_DEPTH];
   logic [1:0]    prev_ix;
   logic [1:0]    old_ix;

   generate
      if (POLL_MAX < 3) begin : g_bad_max
         $error("POLL_MAX must allow the three initial reads");
      end
      for (genvar g = 0; g < RING_DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[g] <= '0;
            else if (sample && cnt[1:0] == 2'(g))
               slot[g] <= rd;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (sample)
         cnt <= cnt + 1'b1;
   end

   always_comb begin
      cnt_n   = {1'b0, cnt} + 1'b1;
      prev_ix = cnt[1:0] - 2'd1;
      old_ix  = cnt[1:0] - 2'd2;
      fin     = sample && (cnt_n >= (CW+1)'(3)) &&
                ((rd == slot[prev_ix]) || (cnt_n >= (CW+1)'(POLL_MAX)));
      pass    = (rd == target);
      fault   = slot[old_ix][STAT_FAULT_BIT];
   end

   // R4
   poll_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(POLL_MAX));

endmodule

// File: rtl/nfps_prog.sv
module nfps_prog #(
   parameter int AW = 20,
   parameter int LW = 16,
   parameter int DEV_SIZE = 1 << 20,
   parameter int POLL_MAX = 10000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   output logic [LW-1:0] src_idx,
   input  logic [7:0]    src_byte,
   output logic          fl_re,
   output logic          fl_we,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_wdata,
   input  logic [7:0]    fl_rdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [1:0]    err_kind,
   output logic          warn
);
   import nfps_pkg::*;

   localparam int SW = ((AW > LW) ? AW : LW) + 1;
   localparam logic [AW-1:0] UNL_A = AW'(12'h555);
   localparam logic [AW-1:0] UNL_B = AW'(12'h2AA);

   generate
      if (AW < 11) begin : g_bad_aw
         $error("AW too narrow for the unlock addresses");
      end
      if (DEV_SIZE < 1 || 64'(DEV_SIZE) > (64'd1 << AW)) begin : g_bad_size
         $error("DEV_SIZE out of range for AW");
      end
   endgenerate

   nfp_st_e       st;
   nfp_err_e      ek;
   logic [AW-1:0] base;
   logic [LW-1:0] len;
   logic [LW-1:0] idx;
   logic          warn_q;

   logic [AW-1:0] tgt_addr;
   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic [1:0]    step;
   logic          last_byte;
   logic          over;
   logic          ring_fin, ring_pass, ring_fault;

   nfps_cmd #(.AW(AW), .UNLOCK_A(UNL_A), .UNLOCK_B(UNL_B)) u_cmd (
      .step     (step),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data)
   );

   nfps_ring #(.POLL_MAX(POLL_MAX)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (st == ST_WR),
      .sample (st == ST_POLL),
      .rd     (fl_rdata),
      .target (src_byte),
      .fin    (ring_fin),
      .pass   (ring_pass),
      .fault  (ring_fault)
   );

   always_comb begin
      tgt_addr  = base + AW'(idx);
      last_byte = ({1'b0, idx} + 1'b1) == {1'b0, len};
      over      = (SW'(base) + SW'(len)) > SW'(DEV_SIZE);
      case (st)
         ST_U1:   step = 2'd0;
         ST_U2:   step = 2'd1;
         default: step = 2'd2;
      endcase
      fl_re    = (st == ST_RDOLD) || (st == ST_POLL);
      fl_we    = (st == ST_U1) || (st == ST_U2) || (st == ST_U3) || (st == ST_WR);
      fl_addr  = (st == ST_U1 || st == ST_U2 || st == ST_U3) ? cmd_addr : tgt_addr;
      fl_wdata = (st == ST_WR) ? src_byte : cmd_data;
      src_idx  = idx;
      busy     = (st != ST_IDLE);
      done     = (st == ST_DONE);
      err_kind = ek;
      err      = (ek != NFP_OK);
      warn     = warn_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ek     <= NFP_OK;
         base   <= '0;
         len    <= '0;
         idx    <= '0;
         warn_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               base   <= req_addr;
               len    <= req_len;
               idx    <= '0;
               warn_q <= 1'b0;
               ek     <= NFP_OK;
               st     <= ST_CHK;
            end
            ST_CHK: begin
               if (over) begin
                  ek <= NFP_RANGE;
                  st <= ST_DONE;
               end else if (len == '0) begin
                  st <= ST_DONE;
               end else begin
                  st <= ST_RDOLD;
               end
            end
            ST_RDOLD: begin
               if (fl_rdata == src_byte) begin
                  if (last_byte) st <= ST_DONE;
                  else begin
                     idx <= idx + 1'b1;
                     st  <= ST_RDOLD;
                  end
               end else begin
                  if ((~fl_rdata & src_byte) != 8'h00) warn_q <= 1'b1;
                  st <= ST_U1;
               end
            end
            ST_U1: st <= ST_U2;
            ST_U2: st <= ST_U3;
            ST_U3: st <= ST_WR;
            ST_WR: st <= ST_POLL;
            ST_POLL: if (ring_fin) begin
               if (ring_pass) begin
                  if (last_byte) st <= ST_DONE;
                  else begin
                     idx <= idx + 1'b1;
                     st  <= ST_RDOLD;
                  end
               end else begin
                  ek <= ring_fault ? NFP_INTERNAL : NFP_NOTAKE;
                  st <= ST_DONE;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R3
   unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we && fl_addr == UNL_B) |-> ($past(fl_we) && $past(fl_wdata) == CMD_UNL1));

   // R3
   bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   // R8
   range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_kind == 2'd1) |-> $past(!fl_we && !fl_re));

   // R1
   skip_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDOLD && fl_rdata == src_byte) |=> !fl_we);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/sim_nfps_prog.sv
`timescale 1ns/1ps
module sim_nfps_prog;

   localparam int AW = 12;
   localparam int LW = 8;
   localparam int DSZ = 64;
   localparam int PMAX = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [LW-1:0] src_idx;
   logic [7:0]    src_byte;
   logic          fl_re, fl_we;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata, fl_rdata;
   logic          busy, done, err, warn;
   logic [1:0]    err_kind;

   always #2.5 clk = ~clk;

   nfps_prog #(.AW(AW), .LW(LW), .DEV_SIZE(DSZ), .POLL_MAX(PMAX)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_len(req_len),
      .src_idx(src_idx), .src_byte(src_byte), .fl_re(fl_re), .fl_we(fl_we),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .busy(busy),
      .done(done), .err(err), .err_kind(err_kind), .warn(warn)
   );

   // data source
   logic [7:0] sbuf [16];
   assign src_byte = sbuf[src_idx[3:0]];

   // flash model
   logic [7:0] mem [64];
   logic       pl_en = 1'b0;
   logic [5:0] pl_a = '0;
   logic [7:0] pl_v = '0;
   logic       fault = 1'b0;
   logic       hang = 1'b0;
   int         seq = 0, nw = 0, nr = 0, seq_err = 0, bsy = 0;
   logic       stuck = 1'b0, tog = 1'b0, fst = 1'b0;
   logic [7:0] pd = '0;

   always @(posedge clk) begin
      if (pl_en) mem[pl_a] <= pl_v;
      if (!hang) stuck <= 1'b0;
      if (fl_we) begin
         nw <= nw + 1;
         case (seq)
            0: if (fl_addr == 12'h555 && fl_wdata == 8'hAA) seq <= 1;
               else seq_err <= seq_err + 1;
            1: if (fl_addr == 12'h2AA && fl_wdata == 8'h55) seq <= 2;
               else begin seq_err <= seq_err + 1; seq <= 0; end
            2: if (fl_addr == 12'h555 && fl_wdata == 8'hA0) seq <= 3;
               else begin seq_err <= seq_err + 1; seq <= 0; end
            default: begin
               seq <= 0;
               pd  <= fl_wdata;
               bsy <= 3;
               fst <= fault;
               stuck <= hang;
               if (fl_addr >= 12'd64) seq_err <= seq_err + 1;
               else if (!fault) mem[fl_addr[5:0]] <= mem[fl_addr[5:0]] & fl_wdata;
            end
         endcase
      end
      if (fl_re) begin
         nr <= nr + 1;
         if (bsy > 0 || stuck) begin
            tog <= ~tog;
            if (bsy > 0) bsy <= bsy - 1;
         end
      end
   end

   assign fl_rdata = (bsy > 0 || stuck) ? {~pd[7], tog, fst, 5'b10101} : mem[fl_addr[5:0]];

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic preload(input int a, input logic [7:0] v);
      @(negedge clk);
      pl_en = 1'b1; pl_a = 6'(a); pl_v = v;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   int done_cnt;
   task automatic run(input int a, input int l);
      int w;
      @(negedge clk);
      req = 1'b1; req_addr = AW'(a); req_len = LW'(l);
      @(negedge clk);
      req = 1'b0;
      w = 0;
      while (!done) begin
         @(negedge clk);
         w++;
         if (w > 3000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected done", w);
            finish_run();
         end
      end
      @(negedge clk);
      chk(!done, "R11 done one cycle", int'(done), 0);
   endtask

   initial begin
      logic [7:0] olds [5];
      logic [7:0] dats [7];
      int r0, w0;
      logic [1:0] ek;
      logic [7:0] exp_m;
      olds = '{8'h00, 8'h0F, 8'hA5, 8'hFF, 8'h3C};
      dats = '{8'h00, 8'h0F, 8'hA5, 8'hFF, 8'h5A, 8'hF0, 8'hC3};
      for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
      for (int i = 0; i < 16; i++) sbuf[i] = 8'hFF;

      repeat (3) @(negedge clk);
      // R10
      chk(!busy && !done && !err && !fl_re && !fl_we, "R10 reset outputs",
          {busy, done, err, fl_re, fl_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fl_re && !fl_we, "R10 idle after reset", {busy, done, fl_re, fl_we}, 0);

      // sweep of old/new pairs, single byte each
      for (int o = 0; o < 5; o++) begin
         for (int d = 0; d < 7; d++) begin
            int a;
            a = (o * 7 + d) % 32;
            preload(a, olds[o]);
            sbuf[0] = dats[d];
            r0 = nr; w0 = nw;
            run(a, 1);
            if (olds[o] == dats[d]) begin
               // R1
               chk(err_kind == 2'd0, "R1 skip status", err_kind, 0);
               chk(nw == w0, "R1 no write on match", nw - w0, 0);
               chk(nr - r0 == 1, "R1 single read", nr - r0, 1);
               chk(!warn, "R2 no warn on skip", warn, 0);
            end else begin
               ek = ((olds[o] & dats[d]) == dats[d]) ? 2'd0 : 2'd3;
               // R5
               chk(err_kind == ek, "R5 result class", err_kind, ek);
               chk(err == (ek != 2'd0), "R11 err flag", err, ek != 2'd0);
               // R2
               chk(warn == ((~olds[o] & dats[d]) != 8'h00), "R2 warn", warn,
                   (~olds[o] & dats[d]) != 8'h00);
               // R3
               chk(nw - w0 == 4, "R3 four writes", nw - w0, 4);
               // R4
               chk(nr - r0 == 6, "R4 poll count", nr - r0, 6);
               exp_m = olds[o] & dats[d];
               chk(mem[a] == exp_m, "R5 memory", mem[a], exp_m);
            end
         end
      end
      chk(seq_err == 0, "R3 command order", seq_err, 0);

      // multi-byte stream
      for (int i = 0; i < 8; i++) begin
         preload(20 + i, 8'hFF);
         sbuf[i] = 8'((i * 37 + 5) | ((i == 3) ? 8'hFF : 8'h00));
      end
      begin
         int nprog;
         nprog = 0;
         for (int i = 0; i < 8; i++) if (sbuf[i] != 8'hFF) nprog++;
         w0 = nw;
         run(20, 8);
         // R7
         chk(err_kind == 2'd0, "R7 stream status", err_kind, 0);
         chk(nw - w0 == 4 * nprog, "R1 writes in stream", nw - w0, 4 * nprog);
         for (int i = 0; i < 8; i++)
            chk(mem[20 + i] == sbuf[i], "R7 stream byte", mem[20 + i], sbuf[i]);
      end

      // failure stops request
      preload(40, 8'hFF); preload(41, 8'h00); preload(42, 8'hFF);
      sbuf[0] = 8'h11; sbuf[1] = 8'h22; sbuf[2] = 8'h33;
      w0 = nw;
      run(40, 3);
      chk(err_kind == 2'd3, "R7 failing byte class", err_kind, 3);
      chk(mem[42] == 8'hFF, "R7 later byte untouched", mem[42], 8'hFF);
      chk(nw - w0 == 8, "R7 writes before stop", nw - w0, 8);
      chk(warn, "R2 sticky warn", warn, 1);

      // internal fault, device settles
      preload(5, 8'hFF);
      sbuf[0] = 8'h12;
      fault = 1'b1;
      r0 = nr;
      run(5, 1);
      // R6
      chk(err_kind == 2'd2, "R6 internal fault", err_kind, 2);
      chk(nr - r0 == 6, "R4 fault poll count", nr - r0, 6);
      chk(mem[5] == 8'hFF, "R6 fault no change", mem[5], 8'hFF);

      // device never settles: ceiling
      hang = 1'b1;
      r0 = nr;
      run(6, 1);
      chk(nr - r0 == 1 + PMAX, "R4 read ceiling", nr - r0, 1 + PMAX);
      chk(err_kind == 2'd2, "R6 ceiling class", err_kind, 2);
      hang = 1'b0; fault = 1'b0;
      repeat (2) @(negedge clk);

      // range
      r0 = nr; w0 = nw;
      run(60, 5);
      // R8
      chk(err_kind == 2'd1, "R8 over range", err_kind, 1);
      chk(nr == r0 && nw == w0, "R8 no bus", (nr - r0) + (nw - w0), 0);
      for (int i = 0; i < 4; i++) begin
         preload(60 + i, 8'h5A);
         sbuf[i] = 8'h5A;
      end
      r0 = nr; w0 = nw;
      run(60, 4);
      chk(err_kind == 2'd0, "R8 exact end accepted", err_kind, 0);
      chk(nr - r0 == 4 && nw == w0, "R8 boundary reads", nr - r0, 4);

      // zero length
      r0 = nr; w0 = nw;
      run(3, 0);
      // R9
      chk(err_kind == 2'd0 && !err, "R9 zero length", err_kind, 0);
      chk(nr == r0 && nw == w0, "R9 no bus", (nr - r0) + (nw - w0), 0);
      chk(seq_err == 0, "R3 final command order", seq_err, 0);

      finish_run();
   end

endmodule